// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block brings up four power-rail enables one after another, in the order A, B, C, D, once a supply-compliance flag reports that the monitored voltage is inside its window and a sequence request is active. A start delay and three stage delays, each counted in clock ticks, set the spacing. When the request is withdrawn, the rails go down in the opposite order, D, C, B, A. The start delay is timed again before D drops.

A loss of compliance (undervoltage or overvoltage) skips all sequencing and drops every rail on the same edge. A fault output reports whether the supply is compliant. A polarity pin selects active-high or active-low rail outputs.

The two asynchronous inputs pass through two-flop synchronizers. All other control pins are plain levels that are expected to be static while a sequence runs. There is no data stream, so no valid/ready handshake exists at the edge of the block.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted and immediately after it, all four rail outputs are inactive and fault_o is 1.
- R2: While seq_req_i is 0, no rail asserts, even with supply_ok_i at 1.
- R3: With supply_ok_i and seq_req_i both 1 and the block idle, rail A asserts on clock edge start_dly_i+4. Edge 1 is the first edge that samples the inputs. Rails only ever step up one at a time in the order A, B, C, D.
- R4: Rails B, C and D each assert dly_b_i+1, dly_c_i+1 and dly_d_i+1 edges after the previous rail asserted. A delay of 0 therefore means the next clock edge.
- R5: When seq_req_i falls with all rails on, rail D deasserts on edge start_dly_i+4, counted from the edge that samples the fall. Rails then drop one at a time in the order D, C, B, A.
- R6: After D drops, C drops dly_d_i+1 edges later, B drops dly_c_i+1 edges after C, and A drops dly_b_i+1 edges after B.
- R7: When supply_ok_i falls, all enabled rails deassert together on edge 3, counted from the sampling edge.
- R8: fault_o goes to 0 on edge 2 after supply_ok_i rises and to 1 on edge 2 after it falls. Edge 1 is the sampling edge.
- R9: With active_low_i at 1, every bit of rail_en_o is inverted: an idle block drives 4'b1111, and an asserted rail reads 0.
- R10: If seq_req_i returns to 1 during a turn-off sequence, the turn-off still completes through rail A. Rail A then asserts again start_dly_i+2 edges after it dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply inside compliance window (asynchronous) |
| seq_req_i | input | 1 | Sequence request, 1 = power up (asynchronous) |
| active_low_i | input | 1 | 1 selects active-low rail outputs |
| start_dly_i | input | CNT_W | Start delay in ticks, used before the first step of both directions |
| dly_b_i | input | CNT_W | Delay after A before B, and after B before A |
| dly_c_i | input | CNT_W | Delay after B before C, and after C before B |
| dly_d_i | input | CNT_W | Delay after C before D, and after D before C |
| rail_en_o | output | 4 | Rail enables, bit 0 = A through bit 3 = D, polarity per active_low_i |
| fault_o | output | 1 | 1 while the supply is not compliant |

## Verification
The assertions assume that the four delay values and the polarity pin change only while every rail is off and the controller is idle. A delay that shrinks under a running counter would let it wrap. The stimulus loads each delay set and the polarity before raising the request, and restores them only after rail A has been seen low. The asynchronous inputs are driven midway between clock edges, so each synchronizer sees a clean level on its first sampling edge and the edge counts in the requirements are exact.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  localparam int RAILS = 4;
  localparam int LVL_W = $clog2(RAILS + 1);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_UP   = 2'd1,
    S_FULL = 2'd2,
    S_DOWN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] tgt,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = (cnt == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  // R4: a running count never wraps past its target back to zero
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !done) |=> (cnt != '0));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             seq_req_i,
  input  logic             active_low_i,
  input  logic [CNT_W-1:0] start_dly_i,
  input  logic [CNT_W-1:0] dly_b_i,
  input  logic [CNT_W-1:0] dly_c_i,
  input  logic [CNT_W-1:0] dly_d_i,
  output logic [RAILS-1:0] rail_en_o,
  output logic             fault_o
);
  logic [1:0]       sync_q;
  logic             vg_s, se_s;
  seq_state_t       state, state_n;
  logic [LVL_W-1:0] lvl, lvl_n;
  logic             first, first_n;
  logic             tmr_clr, tmr_done;
  logic [CNT_W-1:0] tgt;
  logic [RAILS-1:0] en;

  rseq_sync #(.W(2), .STAGES(2)) i_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({supply_ok_i, seq_req_i}),
    .q (sync_q)
  );
  assign vg_s = sync_q[1];
  assign se_s = sync_q[0];

  rseq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk (clk),
    .rst_n (rst_n),
    .clr (tmr_clr),
    .tgt (tgt),
    .done (tmr_done)
  );

  // delay selection: upward steps use the delay owned by the next rail,
  // downward steps use start delay first, then the delay of the rail just dropped
  always_comb begin
    tgt = start_dly_i;
    if (state == S_UP) begin
      case (lvl)
        LVL_W'(0): tgt = start_dly_i;
        LVL_W'(1): tgt = dly_b_i;
        LVL_W'(2): tgt = dly_c_i;
        default:   tgt = dly_d_i;
      endcase
    end else if (state == S_DOWN && !first) begin
      case (lvl)
        LVL_W'(3): tgt = dly_d_i;
        LVL_W'(2): tgt = dly_c_i;
        default:   tgt = dly_b_i;
      endcase
    end
  end

  always_comb begin
    state_n = state;
    lvl_n   = lvl;
    first_n = first;
    tmr_clr = 1'b0;
    case (state)
      S_IDLE: begin
        tmr_clr = 1'b1;
        if (vg_s && se_s) state_n = S_UP;
      end
      S_UP: begin
        if (!vg_s) begin
          state_n = S_IDLE;
          lvl_n   = '0;
        end else if (!se_s) begin
          tmr_clr = 1'b1;
          if (lvl == '0) begin
            state_n = S_IDLE;
          end else begin
            state_n = S_DOWN;
            first_n = 1'b1;
          end
        end else if (tmr_done) begin
          tmr_clr = 1'b1;
          lvl_n   = lvl + LVL_W'(1);
          if (lvl == LVL_W'(RAILS - 1)) state_n = S_FULL;
        end
      end
      S_FULL: begin
        tmr_clr = 1'b1;
        if (!vg_s) begin
          state_n = S_IDLE;
          lvl_n   = '0;
        end else if (!se_s) begin
          state_n = S_DOWN;
          first_n = 1'b1;
        end
      end
      S_DOWN: begin
        if (!vg_s) begin
          state_n = S_IDLE;
          lvl_n   = '0;
        end else if (tmr_done) begin
          tmr_clr = 1'b1;
          first_n = 1'b0;
          lvl_n   = lvl - LVL_W'(1);
          if (lvl == LVL_W'(1)) state_n = S_IDLE;
        end
      end
      default: begin
        state_n = S_IDLE;
        lvl_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lvl   <= '0;
      first <= 1'b0;
    end else begin
      state <= state_n;
      lvl   <= lvl_n;
      first <= first_n;
    end
  end

  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    assign en[g] = (lvl > LVL_W'(g));
  end

  assign rail_en_o = en ^ {RAILS{active_low_i}};
  assign fault_o   = ~vg_s;

  // R2: idle without a request keeps every rail off
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !se_s) |=> (lvl == '0));

  // R3: rail count only moves one step at a time, except the drop to zero
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) && (lvl != '0) |->
      ((lvl == $past(lvl) + LVL_W'(1)) || (lvl == $past(lvl) - LVL_W'(1))));

  // R5: a turn-off never raises a rail
  p_down_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DOWN) |=> (lvl <= $past(lvl)));

  // R7: losing compliance clears every rail on the next edge
  p_dump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vg_s |=> (lvl == '0));

  // R4: the all-on state always holds every rail
  p_full_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FULL) |-> (lvl == LVL_W'(RAILS)));
endmodule

// File: tb/test_rail_sequencer.sv
`timescale 1ns/1ps
module test_rail_sequencer;
  localparam int CW = 8;
  localparam int NV = 4;
  // each row: start, b, c, d
  localparam int VEC [NV][4] = '{'{0, 0, 0, 0}, '{3, 1, 2, 5},
                                 '{7, 4, 0, 2}, '{1, 6, 3, 0}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vg = 1'b0, se = 1'b0, pol = 1'b0;
  logic [CW-1:0] ds = '0, db = '0, dc = '0, dd = '0;
  logic [3:0]    rail;
  logic          fault;
  int            nchk = 0, nfail = 0;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.CNT_W(CW)) i_rail_sequencer (
    .clk (clk), .rst_n (rst_n), .supply_ok_i (vg), .seq_req_i (se),
    .active_low_i (pol), .start_dly_i (ds), .dly_b_i (db), .dly_c_i (dc),
    .dly_d_i (dd), .rail_en_o (rail), .fault_o (fault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // records the first cycle (edge 1 = first edge after call) each bit equals want
  task automatic track(input bit want, output int tc [4]);
    int cyc = 0;
    for (int i = 0; i < 4; i++) tc[i] = -1;
    while ((tc[0] < 0 || tc[1] < 0 || tc[2] < 0 || tc[3] < 0) && cyc < 3000) begin
      @(posedge clk); #1;
      cyc++;
      for (int i = 0; i < 4; i++) if (tc[i] < 0 && rail[i] == want) tc[i] = cyc;
    end
  endtask

  task automatic set_dly(input int s, input int b, input int c, input int d);
    @(negedge clk);
    ds = CW'(s); db = CW'(b); dc = CW'(c); dd = CW'(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int tc [4];
    int ex [4];
    int bad;
    int afall;
    repeat (3) @(posedge clk);
    #1;
    chk(rail == 4'h0, "R1 rails in reset", rail, 0);
    chk(fault == 1'b1, "R1 fault in reset", fault, 1);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rail == 4'h0 && fault, "R1 after reset", {fault, rail}, 16);

    // R8: fault falls on edge 2
    @(negedge clk) vg = 1'b1;
    @(posedge clk); #1;
    chk(fault == 1'b1, "R8 fault edge1", fault, 1);
    @(posedge clk); #1;
    chk(fault == 1'b0, "R8 fault edge2", fault, 0);

    // R2: no request, no rails
    bad = 0;
    repeat (40) begin
      @(posedge clk); #1;
      if (rail != 4'h0) bad++;
    end
    chk(bad == 0, "R2 no start without request", bad, 0);

    // table of delay sets: R3 R4 up, R5 R6 down
    for (int v = 0; v < NV; v++) begin
      set_dly(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      @(negedge clk) se = 1'b1;
      track(1'b1, tc);
      ex[0] = VEC[v][0] + 4;
      ex[1] = ex[0] + VEC[v][1] + 1;
      ex[2] = ex[1] + VEC[v][2] + 1;
      ex[3] = ex[2] + VEC[v][3] + 1;
      chk(tc[0] == ex[0], "R3 rail A on", tc[0], ex[0]);
      for (int i = 1; i < 4; i++) chk(tc[i] == ex[i], "R4 rail on", tc[i], ex[i]);
      @(negedge clk) se = 1'b0;
      track(1'b0, tc);
      ex[3] = VEC[v][0] + 4;
      ex[2] = ex[3] + VEC[v][3] + 1;
      ex[1] = ex[2] + VEC[v][2] + 1;
      ex[0] = ex[1] + VEC[v][1] + 1;
      chk(tc[3] == ex[3], "R5 rail D off", tc[3], ex[3]);
      for (int i = 0; i < 3; i++) chk(tc[i] == ex[i], "R6 rail off", tc[i], ex[i]);
    end

    // R7: compliance loss drops all rails together on edge 3
    set_dly(2, 1, 1, 1);
    @(negedge clk) se = 1'b1;
    track(1'b1, tc);
    @(negedge clk) vg = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(fault == 1'b1, "R8 fault rises edge2", fault, 1);
    chk(rail == 4'hF, "R7 rails held edge2", rail, 15);
    @(posedge clk); #1;
    chk(rail == 4'h0, "R7 all rails dropped edge3", rail, 0);
    @(negedge clk) se = 1'b0;
    repeat (4) @(negedge clk);
    vg = 1'b1;
    repeat (4) @(negedge clk);

    // R9: active-low polarity
    pol = 1'b1;
    #1;
    chk(rail == 4'hF, "R9 idle active-low", rail, 15);
    set_dly(1, 0, 0, 0);
    @(negedge clk) se = 1'b1;
    track(1'b0, tc);
    chk(tc[0] == 5, "R9 rail A asserts low", tc[0], 5);
    chk(rail == 4'h0, "R9 all asserted low", rail, 0);
    @(negedge clk) se = 1'b0;
    track(1'b1, tc);
    chk(tc[0] == 8, "R9 rail A released high", tc[0], 8);
    @(negedge clk) pol = 1'b0;
    #1;
    chk(rail == 4'h0, "R9 back to active-high", rail, 0);

    // R10: request returns during turn-off
    set_dly(2, 3, 3, 3);
    @(negedge clk) se = 1'b1;
    track(1'b1, tc);
    @(negedge clk) se = 1'b0;
    for (int i = 0; i < 4; i++) tc[i] = -1;
    afall = -1;
    begin
      int cyc = 0;
      int arise = -1;
      while (arise < 0 && cyc < 3000) begin
        @(posedge clk); #1;
        cyc++;
        for (int i = 0; i < 4; i++) if (tc[i] < 0 && rail[i] == 1'b0) tc[i] = cyc;
        if (tc[3] == cyc) se = 1'b1;
        if (tc[0] > 0 && cyc > tc[0] && rail[0]) arise = cyc;
      end
      chk(tc[3] == 6, "R10 rail D off", tc[3], 6);
      chk(tc[2] == 10, "R10 rail C still off", tc[2], 10);
      chk(tc[1] == 14, "R10 rail B still off", tc[1], 14);
      chk(tc[0] == 18, "R10 rail A still off", tc[0], 18);
      chk(arise == tc[0] + 4, "R10 rail A restarts", arise, tc[0] + 4);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule